// File: doc/BRIEF.md
# Flip-Flop Ternary Content-Addressable Memory with Hit Iteration

The block stores a set of data words in flip-flop lines, one word and one valid flag per line. Any line can be written or invalidated by index. A search presents a key and a per-bit ignore mask. Every valid line compares the key against its stored word in parallel. Bits whose mask bit is 1 always count as equal, so the block behaves as a ternary CAM.

The per-line results are captured into a hit register on the clock edge that takes the search. After that, the block reports one matching line index per cycle, lowest index first. Each reported hit is retired on the next edge, so all matching indices appear in turn. When the hit register is empty, the hit flag drops. A new search replaces any hits that have not been reported yet. A host uses the block by writing lines, issuing a search, and then reading `hit_addr` while `hit_valid` is high.

Top module: `tcam_core`

## Requirements
- R1: When `rst` is high at a clock edge, every line becomes invalid and the hit register is emptied. `hit_valid` is 0 from the following cycle on.
- R2: When `wr_en` is high and `inv_en` is low, the line at `line_sel` loads `word_in` and becomes valid. A search issued in the very next cycle sees the new word.
- R3: When `inv_en` is high, the line at `line_sel` becomes invalid. That line then matches no later search until it is written again.
- R4: A line matches only if it is valid and all of its unmasked stored bits equal the key on `word_in`. Lines that were never written do not match.
- R5: While `hit_valid` is 1, `hit_addr` is the smallest line index that is still set in the hit register.
- R6: A search accepted at edge T makes the hits visible from cycle T+1. Each cycle in which a hit is shown retires that hit at the next edge. `hit_valid` stays 1 for exactly as many cycles as there are matching lines, and the indices appear in ascending order.
- R7: A bit set to 1 in `key_mask` excludes that bit from comparison. An all-ones mask matches every valid line.
- R8: A search accepted while earlier hits are still pending discards them and reports only the new result.
- R9: `srch_en` is ignored in any cycle where `wr_en` or `inv_en` is high. Hit iteration then carries on as if no search had been issued.
- R10: When `wr_en` and `inv_en` are both high for the same line, that line ends invalid.
- R11: The hit register is a snapshot. Writes or invalidations made during iteration do not add, remove or alter pending hits.
- R12: While `hit_valid` is 0, `hit_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store `word_in` into line `line_sel` |
| inv_en | input | 1 | Invalidate line `line_sel` |
| srch_en | input | 1 | Start a search with key `word_in` |
| line_sel | input | $clog2(DEPTH) | Line index for write or invalidate |
| word_in | input | WORD_W | Write data or search key |
| key_mask | input | WORD_W | Per-bit ignore mask for search (1 = don't care) |
| hit_addr | output | $clog2(DEPTH) | Lowest pending matching line index |
| hit_valid | output | 1 | A match is being reported this cycle |

## Verification
Searches are run with the following patterns, each aimed at a different fault:
- An empty memory and a unique exact key, which expose spurious matches from invalid or unwritten lines.
- A key stored in several lines, which shows whether iteration is ascending and retires exactly one hit per cycle.
- Partial masks and the all-ones mask, which separate a mask that is applied from one that is ignored or inverted.
- Searches that collide with writes, invalidations, a pending iteration, or a write made one cycle before, which tell apart the ordering rules for priority, restart and snapshot.

A behavioural model predicts `hit_valid` and `hit_addr` for every cycle.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    // Per-cycle request as seen at the block edge.
    typedef struct packed {
        logic wr;
        logic inv;
        logic srch;
    } tcam_cmd_t;

    // Resolved action of one cycle.
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_UPDATE = 2'd1,
        OP_SEARCH = 2'd2
    } tcam_op_e;

    // Line updates win over a search requested in the same cycle.
    function automatic tcam_op_e tcam_classify(tcam_cmd_t c);
        if (c.wr || c.inv)
            return OP_UPDATE;
        else if (c.srch)
            return OP_SEARCH;
        return OP_NONE;
    endfunction

    // One ternary bit comparison: an ignored bit always agrees.
    function automatic logic tcam_bit_agrees(logic stored, logic key, logic ignore);
        return ignore | ~(stored ^ key);
    endfunction

endpackage

// File: rtl/tcam_line.sv
module tcam_line
    import tcam_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic              inv_sel,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [WORD_W-1:0] key,
    input  logic [WORD_W-1:0] key_mask,
    output logic              hit
);
    logic [WORD_W-1:0] word_q;
    logic              valid_q;
    logic [WORD_W-1:0] bit_eq;

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else if (inv_sel)
            valid_q <= 1'b0;
        else if (wr_sel)
            valid_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_sel)
            word_q <= wr_word;
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign bit_eq[b] = tcam_bit_agrees(word_q[b], key[b], key_mask[b]);
    end

    assign hit = valid_q & (&bit_eq);

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !inv_sel) |=> (valid_q && word_q == $past(wr_word))) else $error("write"); // R2
    AST_INVALIDATE: assert property (@(posedge clk) disable iff (rst)
        inv_sel |=> !valid_q) else $error("invalidate"); // R3
    AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        inv_sel |=> !hit) else $error("invalid line hit"); // R4

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic [DEPTH-1:0] vec,
    output logic [AW-1:0]    idx,
    output logic             any
);
    // Scan from the top down so the lowest set index is the last written.
    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec[i])
                idx = AW'(i);
        end
    end

    assign any = |vec;

endmodule

// File: rtl/tcam_iter_ctrl.sv
module tcam_iter_ctrl
    import tcam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  tcam_op_e         op,
    input  logic [DEPTH-1:0] line_hits,
    input  logic [AW-1:0]    report_idx,
    output logic [DEPTH-1:0] mreg
);
    logic [DEPTH-1:0] retire_mask;

    assign retire_mask = DEPTH'(1) << report_idx;

    always_ff @(posedge clk) begin
        if (rst)
            mreg <= '0;
        else if (op == OP_SEARCH)
            mreg <= line_hits;
        else if (|mreg)
            mreg <= mreg & ~retire_mask;
    end

    AST_ONE_RETIRED: assert property (@(posedge clk) disable iff (rst)
        (op != OP_SEARCH && |mreg) |=> $countones(mreg) == $countones($past(mreg)) - 1)
        else $error("retire count"); // R6
    AST_NO_NEW_BITS: assert property (@(posedge clk) disable iff (rst)
        (op != OP_SEARCH) |=> (mreg & ~$past(mreg)) == '0) else $error("snapshot grew"); // R11
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SEARCH) |=> mreg == $past(line_hits)) else $error("restart"); // R8

endmodule

// File: rtl/tcam_core.sv
module tcam_core
    import tcam_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              inv_en,
    input  logic              srch_en,
    input  logic [AW-1:0]     line_sel,
    input  logic [WORD_W-1:0] word_in,
    input  logic [WORD_W-1:0] key_mask,
    output logic [AW-1:0]     hit_addr,
    output logic              hit_valid
);
    tcam_cmd_t        cmd;
    tcam_op_e         op;
    logic [DEPTH-1:0] line_hits;
    logic [DEPTH-1:0] mreg;

    assign cmd = '{wr: wr_en, inv: inv_en, srch: srch_en};
    assign op  = tcam_classify(cmd);

    for (genvar i = 0; i < DEPTH; i++) begin : g_line
        logic sel;
        assign sel = (line_sel == AW'(i));
        tcam_line #(.WORD_W(WORD_W)) u_line (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (cmd.wr && sel),
            .inv_sel  (cmd.inv && sel),
            .wr_word  (word_in),
            .key      (word_in),
            .key_mask (key_mask),
            .hit      (line_hits[i])
        );
    end

    tcam_iter_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .line_hits  (line_hits),
        .report_idx (hit_addr),
        .mreg       (mreg)
    );

    tcam_prio_enc #(.DEPTH(DEPTH), .AW(AW)) u_enc (
        .vec (mreg),
        .idx (hit_addr),
        .any (hit_valid)
    );

    AST_REPORT_PENDING: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> mreg[hit_addr]) else $error("reported bit not pending"); // R5
    AST_NONE_BELOW: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> (mreg & ((DEPTH'(1) << hit_addr) - DEPTH'(1))) == '0)
        else $error("lower hit skipped"); // R5
    AST_ADDR_PARKED: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |-> hit_addr == '0) else $error("addr not parked"); // R12
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !hit_valid) else $error("hit after reset"); // R1

endmodule

// File: tb/tcam_core_test.sv
module tcam_core_test;
    localparam int W  = 16;
    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, inv_en = 1'b0, srch_en = 1'b0;
    logic [AW-1:0] line_sel = '0;
    logic [W-1:0]  word_in = '0, key_mask = '0;
    logic [AW-1:0] hit_addr;
    logic          hit_valid;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    logic [W-1:0] m_data [D];
    bit           m_val  [D];
    bit           m_hit  [D];

    tcam_core #(.WORD_W(W), .DEPTH(D)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .inv_en(inv_en), .srch_en(srch_en),
        .line_sel(line_sel), .word_in(word_in), .key_mask(key_mask),
        .hit_addr(hit_addr), .hit_valid(hit_valid)
    );

    always #10 clk = ~clk;

    task automatic model_update();
        if (rst) begin
            for (int i = 0; i < D; i++) begin m_val[i] = 0; m_hit[i] = 0; end
            return;
        end
        if (srch_en && !wr_en && !inv_en) begin
            for (int i = 0; i < D; i++)
                m_hit[i] = m_val[i] && (((m_data[i] ^ word_in) & ~key_mask) == '0);
        end else begin
            for (int i = 0; i < D; i++)
                if (m_hit[i]) begin m_hit[i] = 0; break; end
        end
        if (inv_en)
            m_val[line_sel] = 0;
        else if (wr_en) begin
            m_val[line_sel]  = 1;
            m_data[line_sel] = word_in;
        end
    endtask

    task automatic compare(string tag);
        bit exp_any = 0;
        int exp_addr = 0;
        for (int i = D - 1; i >= 0; i--)
            if (m_hit[i]) begin exp_any = 1; exp_addr = i; end
        checks++;
        if (hit_valid !== exp_any) begin
            fails++;
            $display("FAIL %s hit_valid got %0d expected %0d", tag, hit_valid, exp_any);
        end
        checks++;
        if (hit_addr !== AW'(exp_addr)) begin
            fails++;
            $display("FAIL %s hit_addr got %0d expected %0d", tag, hit_addr, exp_addr);
        end
    endtask

    task automatic op(bit w, bit c, bit s, int a, logic [W-1:0] d, logic [W-1:0] m, string tag);
        wr_en = w; inv_en = c; srch_en = s;
        line_sel = AW'(a); word_in = d; key_mask = m;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(tag);
        wr_en = 0; inv_en = 0; srch_en = 0;
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) op(0, 0, 0, 0, '0, '0, tag);
    endtask

    task automatic wr(int a, logic [W-1:0] d, string tag);
        op(1, 0, 0, a, d, '0, tag);
    endtask

    task automatic find(logic [W-1:0] k, logic [W-1:0] m, string tag);
        op(0, 0, 1, 0, k, m, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < D; i++) begin m_val[i] = 0; m_hit[i] = 0; m_data[i] = '0; end
        @(negedge clk);
        rst = 1;
        idle(3, "R1");
        rst = 0;
        idle(1, "R1");
        find(16'h0000, 16'h0000, "R4");        // empty memory: no hit
        idle(1, "R4");
        wr(3, 16'hAAAA, "R2");
        wr(7, 16'hAAAA, "R2");
        wr(12, 16'h1234, "R2");
        wr(0, 16'h5555, "R2");
        find(16'hAAAA, 16'h0000, "R6");        // hits 3 then 7
        idle(3, "R6");
        find(16'h1234, 16'h0000, "R4");
        idle(2, "R4");
        find(16'h1200, 16'h00FF, "R7");        // masked low byte
        idle(2, "R7");
        find(16'h0000, 16'hFFFF, "R7");        // all valid lines
        idle(5, "R5");
        wr(9, 16'hBBBB, "R2");
        find(16'hBBBB, 16'h0000, "R2");        // sees the write of the prior cycle
        idle(2, "R2");
        find(16'h0000, 16'hFFFF, "R8");
        find(16'h5555, 16'h0000, "R8");        // restart discards pending hits
        idle(2, "R8");
        find(16'hAAAA, 16'h0000, "R9");
        op(1, 0, 1, 5, 16'hAAAA, 16'h0000, "R9"); // search ignored, iteration continues
        idle(3, "R9");
        op(0, 1, 1, 0, 16'h5555, 16'h0000, "R9"); // invalidate with search
        idle(2, "R9");
        find(16'hAAAA, 16'h0000, "R9");        // now includes line 5
        idle(4, "R9");
        op(0, 1, 0, 7, '0, '0, "R3");
        find(16'hAAAA, 16'h0000, "R3");
        idle(3, "R3");
        find(16'h5555, 16'h0000, "R3");        // line 0 was invalidated above
        idle(2, "R12");
        op(1, 1, 0, 14, 16'hCCCC, '0, "R10");
        find(16'hCCCC, 16'h0000, "R10");
        idle(2, "R10");
        find(16'hAAAA, 16'h0000, "R11");       // hits 3 and 5
        op(0, 1, 0, 5, '0, '0, "R11");         // reported list unchanged
        op(1, 0, 0, 2, 16'hAAAA, '0, "R11");
        idle(2, "R11");
        for (int i = 0; i < D; i++)
            wr(i, W'((i * 16'h0351) ^ (i % 3)), "R5");
        for (int k = 0; k < 4; k++) begin
            find(W'(k), 16'hFFFC, "R5");
            idle(D / 2, "R6");
        end
        find(16'h0A20, 16'h00FF, "R7");
        idle(4, "R7");
        rst = 1;
        idle(1, "R1");
        rst = 0;
        find(16'h0000, 16'hFFFF, "R1");        // all lines invalid after reset
        idle(2, "R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule